// File: doc/BRIEF.md
# Chained Shift Register Output Driver

This block loads a chain of external serial-in, parallel-out registers from a stream of bytes. A start command carries the number of bytes to send. The block takes that many bytes from a valid/ready input stream. It shifts each byte out on a serial data line with its own shift clock. When the last bit has been clocked, it gives a single active-low pulse on a latch line, so every register output in the chain changes at the same moment.

The byte count is given at run time, so one instance can drive chains of different lengths. Bytes leave in the order they arrive, and the first byte sent settles in the register at the far end of the chain.

A timer sets the width of each shift clock phase and of the latch pulse. Its length in system clocks is the parameter `DIV`, which must be at least 1. The `busy` output is high for the whole transaction. A one-cycle `done` pulse ends the transaction.

Back-pressure on the input stream works as follows. `in_ready` is high only while the shifter is waiting for its next byte. A byte moves on a cycle where both `in_valid` and `in_ready` are high. The producer may hold `in_valid` low for any number of cycles. While it does, the serial lines wait in their idle levels.

Top module: `chain_sr_driver`

## Requirements
- R1: From reset, and whenever `busy` is low, the pins sit at their idle levels: `sr_latch_n` = 1, `sr_clk` = 0 and `sr_data` = 1. At the same time `in_ready` = 0 and `done` = 0.
- R2: Each byte leaves most significant bit first. The first rising edge of `sr_clk` for a byte carries bit 7, and the eighth carries bit 0.
- R3: `sr_data` holds the bit value for at least one cycle before `sr_clk` rises, and it does not change while `sr_clk` is high.
- R4: A transfer of N bytes gives exactly 8*N rising edges of `sr_clk`, all of them before one single low pulse of `sr_latch_n`. There is no latch pulse between bytes.
- R5: A start with a count of 0 gives no `sr_clk` edge, takes no byte, and still gives the latch pulse followed by `done`.
- R6: After a transfer, a chain of 8-bit registers holds the bytes in the order they were supplied, with the first byte farthest from the driver. Seen as one word whose low end is the register nearest the driver, the chain reads {byte0, byte1, ..., byteN-1}.
- R7: Every high phase of `sr_clk`, every low phase that ends in a rising edge, and every low pulse of `sr_latch_n` lasts at least `DIV` system clocks.
- R8: `in_ready` is high only while the shifter needs its next byte. Exactly N bytes are taken per transfer, and no byte is taken while idle. During a stall with `in_ready` high, `sr_clk` stays 0 and `sr_data` stays 1.
- R9: A `start` while `busy` is low raises `busy` from the next clock edge. A `start` while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle. It comes in the cycle where `sr_latch_n` has just returned high, and `busy` is low in that same cycle.
- R11: Once the final bit has been clocked, `sr_data` returns to 1. It stays at 1 through the latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer; taken only while idle |
| start_count | input | CNT_W | Number of bytes in the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | DATA_W | Input byte |
| in_ready | output | 1 | Driver will take the byte at this edge |
| sr_data | output | 1 | Serial data line, idle high |
| sr_clk | output | 1 | Shift clock, idle low |
| sr_latch_n | output | 1 | Active-low latch strobe, idle high |

## Verification
A wrong bit index inside the shifter shows up at the ports as the wrong number of `sr_clk` rising edges before the latch pulse. It also shows up as a chain pattern that is shifted or reversed, and this is visible as soon as the latch pulse of that transfer ends. A byte counter that is off shows up as an extra or missing `in_ready` handshake, or as a latch pulse that comes early or never comes. With the bench's `DIV` of 3, that shows within one byte time, about 48 system clocks. A fault in the phase timer makes a clock phase or latch pulse shorter than `DIV`. That is caught at the very next edge of the affected line.

// File: rtl/sr_drv_pkg.sv
package sr_drv_pkg;

  // One-hot sequencer states; each pin decodes from a single state bit.
  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_FETCH = 5'b00010,
    ST_SETUP = 5'b00100,
    ST_HIGH  = 5'b01000,
    ST_LATCH = 5'b10000
  } sr_state_e;

endpackage

// File: rtl/sr_phase_timer.sv
module sr_phase_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DCW-1:0] cnt_q;

  // tick marks the last cycle of a phase that lasts DIV cycles
  assign tick = run && (cnt_q == DCW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sr_byte_shifter.sv
module sr_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         advance,
  output logic         msb,
  output logic         last_bit
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sreg_q;
  logic [IW-1:0] idx_q;

  assign msb      = sreg_q[W-1];
  assign last_bit = (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '1;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= load_data;
      idx_q  <= IW'(W - 1);
    end else if (advance) begin
      sreg_q <= {sreg_q[W-2:0], 1'b1};
      idx_q  <= idx_q - 1'b1;
    end
  end

endmodule

// File: rtl/sr_seq_ctrl.sv
module sr_seq_ctrl
  import sr_drv_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic             in_valid,
  input  logic             tick,
  input  logic             last_bit,
  output sr_state_e        state,
  output logic             load,
  output logic             advance,
  output logic             run,
  output logic             in_ready,
  output logic             busy,
  output logic             done
);

  sr_state_e        state_q, state_d;
  logic [CNT_W-1:0] left_q;
  logic             byte_end;
  logic             done_q;

  assign state    = state_q;
  assign busy     = (state_q != ST_IDLE);
  assign in_ready = (state_q == ST_FETCH);
  assign run      = (state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_LATCH);
  assign done     = done_q;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    advance  = 1'b0;
    byte_end = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = (start_count == '0) ? ST_LATCH : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (in_valid) begin
          load    = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          state_d = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          if (!last_bit) begin
            advance = 1'b1;
            state_d = ST_SETUP;
          end else begin
            byte_end = 1'b1;
            state_d  = (left_q == CNT_W'(1)) ? ST_LATCH : ST_FETCH;
          end
        end
      end
      ST_LATCH: begin
        if (tick) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_LATCH) && tick;
      if ((state_q == ST_IDLE) && start) begin
        left_q <= start_count;
      end else if (byte_end) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/chain_sr_driver.sv
module chain_sr_driver
  import sr_drv_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              sr_data,
  output logic              sr_clk,
  output logic              sr_latch_n
);

  generate
    if (DIV < 1) begin : g_bad_div
      $error("DIV must be at least 1");
    end
  endgenerate

  sr_state_e state;
  logic      tick, run, load, advance, msb, last_bit;

  sr_phase_timer #(.DIV(DIV)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  sr_byte_shifter #(.W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_data(in_data),
    .advance  (advance),
    .msb      (msb),
    .last_bit (last_bit)
  );

  sr_seq_ctrl #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_count(start_count),
    .in_valid   (in_valid),
    .tick       (tick),
    .last_bit   (last_bit),
    .state      (state),
    .load       (load),
    .advance    (advance),
    .run        (run),
    .in_ready   (in_ready),
    .busy       (busy),
    .done       (done)
  );

  // Pins decode straight from one-hot state bits.
  assign sr_clk     = (state == ST_HIGH);
  assign sr_latch_n = (state != ST_LATCH);
  assign sr_data    = ((state == ST_SETUP) || (state == ST_HIGH)) ? msb : 1'b1;

endmodule

// File: rtl/chain_sr_driver_chk.sv
module chain_sr_driver_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic in_ready,
  input logic sr_data,
  input logic sr_clk,
  input logic sr_latch_n
);

  localparam int unsigned CAP = 32'd1048576;

  int unsigned hi_run, lo_run, lat_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run  <= 0;
      lo_run  <= 0;
      lat_run <= 0;
    end else begin
      hi_run  <= sr_clk ? ((hi_run == CAP) ? hi_run : hi_run + 1) : 0;
      lo_run  <= !sr_clk ? ((lo_run == CAP) ? lo_run : lo_run + 1) : 0;
      lat_run <= !sr_latch_n ? ((lat_run == CAP) ? lat_run : lat_run + 1) : 0;
    end
  end

  p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sr_latch_n && !sr_clk && sr_data && !in_ready));

  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_clk |-> $stable(sr_data));

  p_latch_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_latch_n |-> (!sr_clk && !in_ready && busy));

  p_high_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_clk) |-> (hi_run >= DIV));

  p_low_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_clk) |-> (lo_run >= DIV));

  p_latch_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_latch_n) |-> (lat_run >= DIV));

  p_stall_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !sr_clk && sr_data && sr_latch_n));

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sr_latch_n && $past(!sr_latch_n)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_data_high_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_latch_n |-> sr_data);

endmodule

bind chain_sr_driver chain_sr_driver_chk #(.DIV(DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .in_ready  (in_ready),
  .sr_data   (sr_data),
  .sr_clk    (sr_clk),
  .sr_latch_n(sr_latch_n)
);

// File: tb/tb_chain_sr_driver.sv
`timescale 1ns/100ps
module tb_chain_sr_driver;

  localparam int DIV = 3;
  localparam int NV  = 7;
  // vector: count[47:40], bytes right-aligned[39:8] (first byte highest), gap[7:0]
  localparam logic [47:0] VEC [NV] = '{
    {8'd1, 32'h000000A5, 8'd0},
    {8'd1, 32'h00000001, 8'd0},
    {8'd1, 32'h00000080, 8'd2},
    {8'd2, 32'h00001234, 8'd3},
    {8'd3, 32'h00C35A0F, 8'd1},
    {8'd4, 32'hDEADBEEF, 8'd0},
    {8'd4, 32'h00FF8001, 8'd5}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_count = '0;
  logic       busy, done;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, sr_data, sr_clk, sr_latch_n;

  always #2.5 clk = ~clk;

  chain_sr_driver #(.DIV(DIV), .DATA_W(8), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .busy(busy), .done(done), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .sr_data(sr_data), .sr_clk(sr_clk), .sr_latch_n(sr_latch_n)
  );

  int total = 0;
  int bad   = 0;

  // ---------------- port monitor (samples at falling edge) ----------------
  logic        mon_clr = 1'b0;
  logic [31:0] chain;
  logic        first_bit;
  int bits, pulses, hs, setup_bad, done_cnt, done_bad, dout_bad, rise_after_latch;
  int run_len, lat_len, min_hi, min_lo, min_lat;
  logic p_sclk = 1'b0, p_latch = 1'b1, p_dout = 1'b1;

  always @(negedge clk) begin
    if (mon_clr) begin
      chain = '0; first_bit = 1'b0; bits = 0; pulses = 0; hs = 0;
      setup_bad = 0; done_cnt = 0; done_bad = 0; dout_bad = 0; rise_after_latch = 0;
      run_len = 1; lat_len = 0; min_hi = 9999; min_lo = 9999; min_lat = 9999;
    end else if (rst_n) begin
      if (sr_clk && !p_sclk) begin
        chain = {chain[30:0], sr_data};
        if (bits == 0) first_bit = sr_data;
        bits++;
        if (pulses != 0) rise_after_latch++;
        if (sr_data != p_dout) setup_bad++;
      end
      if (sr_clk && p_sclk && (sr_data != p_dout)) setup_bad++;
      if (sr_clk == p_sclk) run_len++;
      else begin
        if (p_sclk) min_hi = (run_len < min_hi) ? run_len : min_hi;
        else        min_lo = (run_len < min_lo) ? run_len : min_lo;
        run_len = 1;
      end
      if (!sr_latch_n) begin
        lat_len++;
        if (!sr_data) dout_bad++;
      end
      if (sr_latch_n && !p_latch) begin
        pulses++;
        min_lat = (lat_len < min_lat) ? lat_len : min_lat;
        lat_len = 0;
      end
      if (in_valid && in_ready) hs++;
      if (done) begin
        done_cnt++;
        if (busy || !sr_latch_n || p_latch) done_bad++;
      end
    end
    p_sclk = sr_clk; p_latch = sr_latch_n; p_dout = sr_data;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_mon();
    mon_clr = 1'b1; step(); mon_clr = 1'b0;
  endtask

  task automatic feed(input int n, input logic [31:0] bytes, input int gap);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      for (int g = 0; g < gap; g++) step();
      in_valid = 1'b1;
      in_data  = bytes[8*(n-1-i) +: 8];
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      step();
      in_valid = 1'b0;
    end
  endtask

  task automatic wait_done();
    forever begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  task automatic run_xfer(input int n, input logic [31:0] bytes, input int gap,
                          input bit spurious);
    clear_mon();
    start = 1'b1; start_count = 8'(n);
    step();
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    step();
    fork
      feed(n, bytes, gap);
      wait_done();
      if (spurious) begin
        repeat (20) step();
        start = 1'b1; start_count = 8'd5;
        step();
        start = 1'b0;
      end
    join
    repeat (4) step();
    @(negedge clk);
    chk(chain == bytes, "R6", "chain contents", chain, bytes);
    if (n > 0) chk(first_bit == bytes[8*n-1], "R2", "first bit is msb", first_bit, bytes[8*n-1]);
    chk(bits == 8*n, "R4", "rising edge count", bits, 8*n);
    chk(pulses == 1, "R4", "latch pulse count", pulses, 1);
    chk(rise_after_latch == 0, "R4", "edges after latch", rise_after_latch, 0);
    chk(hs == n, "R8", "bytes taken", hs, n);
    chk(setup_bad == 0, "R3", "data moved near clock", setup_bad, 0);
    chk(min_lat >= DIV, "R7", "latch width", min_lat, DIV);
    if (n > 0) begin
      chk(min_hi >= DIV, "R7", "clock high width", min_hi, DIV);
      chk(min_lo >= DIV, "R7", "clock low width", min_lo, DIV);
    end
    chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    chk(done_bad == 0, "R10", "done alignment", done_bad, 0);
    chk(dout_bad == 0, "R11", "data low during latch", dout_bad, 0);
    chk(sr_data && !sr_clk && sr_latch_n && !busy, "R1", "idle levels after xfer",
        {sr_data, sr_clk, sr_latch_n, busy}, 4'b1010);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) step();
    @(negedge clk);
    chk({sr_latch_n, sr_clk, sr_data, busy, done, in_ready} == 6'b101000, "R1",
        "levels in reset", {sr_latch_n, sr_clk, sr_data, busy, done, in_ready}, 6'b101000);
    rst_n = 1'b1;
    step();
    @(negedge clk);
    chk({sr_latch_n, sr_clk, sr_data, busy, done, in_ready} == 6'b101000, "R1",
        "levels after reset", {sr_latch_n, sr_clk, sr_data, busy, done, in_ready}, 6'b101000);

    // R8: byte offered while idle is not taken
    clear_mon();
    in_valid = 1'b1; in_data = 8'h3C;
    repeat (10) step();
    @(negedge clk);
    chk(hs == 0 && !in_ready, "R8", "handshake while idle", hs, 0);
    chk(bits == 0, "R8", "edges while idle", bits, 0);
    in_valid = 1'b0;

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_xfer(int'(VEC[v][47:40]), VEC[v][39:8], int'(VEC[v][7:0]), 1'b0);
    end

    // R5: count of zero
    run_xfer(0, 32'h0, 0, 1'b0);
    chk(bits == 0, "R5", "no edges for zero count", bits, 0);
    chk(pulses == 1 && done_cnt == 1, "R5", "latch and done for zero count",
        pulses, 1);

    // R9: start while busy is ignored
    run_xfer(2, 32'h00005AA5, 2, 1'b1);
    chk(bits == 16 && hs == 2, "R9", "start during busy ignored", bits, 16);

    // R8: byte offered after finishing is not taken
    clear_mon();
    in_valid = 1'b1; in_data = 8'hFF;
    repeat (8) step();
    @(negedge clk);
    chk(hs == 0 && bits == 0, "R8", "handshake after done", hs, 0);
    in_valid = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule